// File: doc/BRIEF.md
# Broadcast Coherence Read Sequencer

This block sits on the interconnect side of a small coherent system. It serves the read command stream of a fixed number of caching masters. When a master asks for a line, the sequencer broadcasts a probe to every other master. It collects one completion from each probed master, and only then answers the requester with data and coherency flags. A probe completes in one of two ways: the master sends a probe success, or it sends a tagged write-back whose identifier matches the probe.

Write-backs land in a small backing memory held inside the block. Once every probe has completed, the response reads that memory, so data returned to the requester is always clean. The block handles exactly one read transaction at a time. It keeps that transaction open until the requester acknowledges the response, and no other read command is accepted before then. Write commands are never stalled.

A make-invalid request can lose a race. This happens when another master's invalidating request for the same line is accepted first. The losing request later receives an abort.

Top module: `coh_read_seq`

## Requirements
- R1: A read command is accepted only while no transaction is open. Among the masters requesting in that cycle, the lowest-indexed one is accepted, and at most one ready bit is high in any cycle.
- R2: The probe is driven for exactly one cycle, the cycle after acceptance. It carries the request address and an ID equal to the count of previously accepted read commands, modulo 2^ID_W. `prb_cmd_share` is 1 for readShared (op 0) and 0 otherwise.
- R3: readShared (op 0), readUnique (op 1) and makeInvalid (op 3) probe every master except the requester.
- R4: A probed master completes on `prb_rsp_valid`, or on a tagged write of kind 0 (writeInvalid) or kind 1 (writeShare) whose ID equals the probe ID. A tagged evict (kind 2) or a write with a different ID does not complete it. The response becomes valid in the cycle after the last completion.
- R5: readOnce (op 2) sends no probe and returns data (kind 0) with both flags 0.
- R6: readShared returns shared=1, owner=0 if any probed master kept a copy, and shared=0, owner=1 otherwise. A master keeps a copy when it answers with `prb_rsp_kept`=1 or completes with writeShare. readUnique returns shared=0, owner=1.
- R7: Write kinds 0 and 1 to a mapped address update the backing memory. Kinds 2 and 3 do not. Response data equals the memory contents after all probe write-backs.
- R8: Writes are taken in every cycle, including while probes are outstanding, and a later read returns the written value.
- R9: An address at or above MAP_WORDS returns error (kind 3) with no probe.
- R10: makeInvalid returns success (kind 1) with shared=0, owner=1. Suppose a master has a makeInvalid pending for the same address when another master's invalidating command is accepted. That pending makeInvalid is then answered with abort (kind 2) and sends no probe.
- R11: The response holds its kind and destination while `rd_rsp_ready` is low. After the response is taken, no read command is accepted until `rd_ack_valid` arrives from the requester. An acknowledgement from any other master is ignored.
- R12: After reset there is no response, no probe and empty memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd_valid | input | N_MASTERS | Per-master read command request |
| rd_cmd_ready | output | N_MASTERS | Per-master read command accept |
| rd_cmd_op | input | N_MASTERS x 2 | Read opcode (0 shared, 1 unique, 2 once, 3 makeInvalid) |
| rd_cmd_addr | input | N_MASTERS x ADDR_W | Line address |
| rd_rsp_valid | output | 1 | Response valid |
| rd_rsp_ready | input | 1 | Response taken |
| rd_rsp_dst | output | clog2(N_MASTERS) | Requester index |
| rd_rsp_kind | output | 2 | 0 data, 1 success, 2 abort, 3 error |
| rd_rsp_data | output | DATA_W | Line data |
| rd_rsp_shared | output | 1 | Granted copy is shared |
| rd_rsp_owner | output | 1 | Granted copy is owner |
| rd_ack_valid | input | N_MASTERS | Per-master response acknowledge |
| prb_cmd_valid | output | N_MASTERS | Probe targets |
| prb_cmd_share | output | 1 | 1 make-shared, 0 make-invalid |
| prb_cmd_id | output | ID_W | Probe identifier |
| prb_cmd_addr | output | ADDR_W | Probed line |
| prb_rsp_valid | input | N_MASTERS | Probe success |
| prb_rsp_kept | input | N_MASTERS | Master still holds a copy |
| wr_cmd_valid | input | N_MASTERS | Write command |
| wr_cmd_kind | input | N_MASTERS x 2 | 0 writeInvalid, 1 writeShare, 2 evict, 3 no-data |
| wr_cmd_tagged | input | N_MASTERS | Write answers a probe |
| wr_cmd_id | input | N_MASTERS x ID_W | Probe ID of a tagged write |
| wr_cmd_addr | input | N_MASTERS x ADDR_W | Write address |
| wr_cmd_data | input | N_MASTERS x DATA_W | Write data |

## Verification
The bench runs one transaction of each opcode, and each is built to separate the cases that matter to it:
- readShared runs twice, once with a probed master that keeps its copy and once with a writeShare completion, so the shared and owner flag cases are each exercised.
- readUnique gets a mixed completion: a tagged evict, then a matching writeInvalid, then a probe success. This shows that only valid completions empty the wait and that forwarded write-back data reaches the response.
- Two simultaneous makeInvalid requests to one line test arbitration and the abort path.
- Two simultaneous requests of different kinds, together with a stalled response, an acknowledgement from the wrong master and an untagged write during the probe wait, cover the hold rules and the rule that writes are never blocked.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    OP_RD_SHARED = 2'd0,
    OP_RD_UNIQUE = 2'd1,
    OP_RD_ONCE   = 2'd2,
    OP_MAKE_INV  = 2'd3
  } rd_op_e;

  typedef enum logic [1:0] {
    RSP_DATA  = 2'd0,
    RSP_OK    = 2'd1,
    RSP_ABORT = 2'd2,
    RSP_ERR   = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    WR_INVAL = 2'd0,
    WR_SHARE = 2'd1,
    WR_EVICT = 2'd2,
    WR_NODAT = 2'd3
  } wr_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP,
    ST_ACK
  } seq_state_e;

  // write kinds that carry a line image
  function automatic logic wr_has_data(logic [1:0] kind);
    return (kind == WR_INVAL) || (kind == WR_SHARE);
  endfunction

  // requests that take every other copy away
  function automatic logic op_invalidates(logic [1:0] op);
    return (op == OP_RD_UNIQUE) || (op == OP_MAKE_INV);
  endfunction

  // response class chosen when the command is accepted
  function automatic logic [1:0] pick_kind(logic mapped, logic lost, logic [1:0] op);
    if (!mapped)                    return RSP_ERR;
    if (lost && op == OP_MAKE_INV)  return RSP_ABORT;
    if (op == OP_MAKE_INV)          return RSP_OK;
    return RSP_DATA;
  endfunction

  // {shared, owner} granted to the requester
  function automatic logic [1:0] grant_flags(logic [1:0] op, logic [1:0] kind, logic kept);
    if (kind == RSP_OK) return 2'b01;
    if (kind != RSP_DATA) return 2'b00;
    case (op)
      OP_RD_SHARED: return kept ? 2'b10 : 2'b01;
      OP_RD_UNIQUE: return 2'b01;
      default:      return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/coh_fixed_arb.sv
module coh_fixed_arb #(
  parameter int N_REQ = 3
) (
  input  logic [N_REQ-1:0]         req,
  output logic [N_REQ-1:0]         grant,
  output logic [$clog2(N_REQ)-1:0] grant_idx,
  output logic                     any
);
  localparam int IDX_W = $clog2(N_REQ);

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grant_idx = IDX_W'(i);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/coh_probe_tracker.sv
module coh_probe_tracker
  import coh_pkg::*;
#(
  parameter int N_MASTERS = 3,
  parameter int ID_W      = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic [N_MASTERS-1:0]             load_mask,
  input  logic                             share_probe,
  input  logic [ID_W-1:0]                  cur_id,
  input  logic [N_MASTERS-1:0]             prb_rsp_valid,
  input  logic [N_MASTERS-1:0]             prb_rsp_kept,
  input  logic [N_MASTERS-1:0]             wr_valid,
  input  logic [N_MASTERS-1:0][1:0]        wr_kind,
  input  logic [N_MASTERS-1:0]             wr_tagged,
  input  logic [N_MASTERS-1:0][ID_W-1:0]   wr_id,
  output logic [N_MASTERS-1:0]             mask,
  output logic                             empty_next,
  output logic                             kept
);
  logic [N_MASTERS-1:0] wr_hit;
  logic [N_MASTERS-1:0] done;
  logic [N_MASTERS-1:0] mask_next;
  logic                 keep_hit;

  always_comb begin
    done     = '0;
    keep_hit = 1'b0;
    for (int m = 0; m < N_MASTERS; m++) begin
      wr_hit[m] = wr_valid[m] && wr_tagged[m] && wr_has_data(wr_kind[m]) && (wr_id[m] == cur_id);
      if (mask[m] && (prb_rsp_valid[m] || wr_hit[m])) begin
        done[m] = 1'b1;
        if (share_probe && ((prb_rsp_valid[m] && prb_rsp_kept[m]) ||
                            (wr_hit[m] && wr_kind[m] == WR_SHARE)))
          keep_hit = 1'b1;
      end
    end
    mask_next = load ? load_mask : (mask & ~done);
  end

  assign empty_next = (mask_next == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      kept <= 1'b0;
    end else begin
      mask <= mask_next;
      kept <= load ? 1'b0 : (kept | keep_hit);
    end
  end

  AST_MASK_ONLY_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((mask & ~$past(mask)) == '0)); // R4

  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0 && !load) |=> (mask == '0)); // R4
endmodule

// File: rtl/coh_backing_mem.sv
module coh_backing_mem #(
  parameter int N_PORTS = 3,
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [N_PORTS-1:0]                     wr_en,
  input  logic [N_PORTS-1:0][$clog2(DEPTH)-1:0]  wr_idx,
  input  logic [N_PORTS-1:0][DATA_W-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0]               rd_idx,
  output logic [DATA_W-1:0]                      rd_data
);
  logic [DATA_W-1:0] store [DEPTH];

  // ascending port order: the highest index wins a same-line collision
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      for (int p = 0; p < N_PORTS; p++)
        if (wr_en[p]) store[wr_idx[p]] <= wr_data[p];
    end
  end

  assign rd_data = store[rd_idx];
endmodule

// File: rtl/coh_read_seq.sv
module coh_read_seq
  import coh_pkg::*;
#(
  parameter int N_MASTERS = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int MAP_WORDS = 16,
  parameter int ID_W      = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [N_MASTERS-1:0]                 rd_cmd_valid,
  output logic [N_MASTERS-1:0]                 rd_cmd_ready,
  input  logic [N_MASTERS-1:0][1:0]            rd_cmd_op,
  input  logic [N_MASTERS-1:0][ADDR_W-1:0]     rd_cmd_addr,
  output logic                                 rd_rsp_valid,
  input  logic                                 rd_rsp_ready,
  output logic [$clog2(N_MASTERS)-1:0]         rd_rsp_dst,
  output logic [1:0]                           rd_rsp_kind,
  output logic [DATA_W-1:0]                    rd_rsp_data,
  output logic                                 rd_rsp_shared,
  output logic                                 rd_rsp_owner,
  input  logic [N_MASTERS-1:0]                 rd_ack_valid,
  output logic [N_MASTERS-1:0]                 prb_cmd_valid,
  output logic                                 prb_cmd_share,
  output logic [ID_W-1:0]                      prb_cmd_id,
  output logic [ADDR_W-1:0]                    prb_cmd_addr,
  input  logic [N_MASTERS-1:0]                 prb_rsp_valid,
  input  logic [N_MASTERS-1:0]                 prb_rsp_kept,
  input  logic [N_MASTERS-1:0]                 wr_cmd_valid,
  input  logic [N_MASTERS-1:0][1:0]            wr_cmd_kind,
  input  logic [N_MASTERS-1:0]                 wr_cmd_tagged,
  input  logic [N_MASTERS-1:0][ID_W-1:0]       wr_cmd_id,
  input  logic [N_MASTERS-1:0][ADDR_W-1:0]     wr_cmd_addr,
  input  logic [N_MASTERS-1:0][DATA_W-1:0]     wr_cmd_data
);
  localparam int MIDX_W = $clog2(N_MASTERS);
  localparam int IDX_W  = $clog2(MAP_WORDS);

  seq_state_e           state, state_nx;
  logic [MIDX_W-1:0]    cur_src;
  logic [1:0]           cur_op;
  logic [ADDR_W-1:0]    cur_addr;
  logic [ID_W-1:0]      cur_id;
  logic [1:0]           cur_kind;
  logic [ID_W-1:0]      txn_ctr;
  logic [N_MASTERS-1:0] lost, lost_nx;

  // arbitration
  logic [N_MASTERS-1:0] arb_grant;
  logic [MIDX_W-1:0]    g_idx;
  logic                 arb_any;

  coh_fixed_arb #(.N_REQ(N_MASTERS)) u_arb (
    .req       (rd_cmd_valid),
    .grant     (arb_grant),
    .grant_idx (g_idx),
    .any       (arb_any)
  );

  // named events for the assertions
  logic ev_accept, ev_issue, ev_rsp_fire, ev_ack;
  assign ev_accept   = (state == ST_IDLE) && arb_any;
  assign ev_issue    = (state == ST_ISSUE);
  assign ev_rsp_fire = rd_rsp_valid && rd_rsp_ready;
  assign ev_ack      = (state == ST_ACK) && rd_ack_valid[cur_src];

  assign rd_cmd_ready = (state == ST_IDLE) ? arb_grant : '0;

  // decode of the command being accepted
  logic [1:0]           g_op;
  logic [ADDR_W-1:0]    g_addr;
  logic                 g_mapped, g_probe;
  logic [1:0]           g_kind;
  logic [N_MASTERS-1:0] g_mask;

  always_comb begin
    g_op     = rd_cmd_op[g_idx];
    g_addr   = rd_cmd_addr[g_idx];
    g_mapped = (g_addr < ADDR_W'(MAP_WORDS));
    g_kind   = pick_kind(g_mapped, lost[g_idx], g_op);
    g_probe  = (g_kind == RSP_DATA || g_kind == RSP_OK) && (g_op != OP_RD_ONCE);
    g_mask   = g_probe ? ~(N_MASTERS'(1) << g_idx) : '0;
  end

  // losers of a make-invalid race
  always_comb begin
    lost_nx = lost;
    if (ev_accept) begin
      lost_nx[g_idx] = 1'b0;
      if (g_probe && op_invalidates(g_op)) begin
        for (int m = 0; m < N_MASTERS; m++) begin
          if (MIDX_W'(m) != g_idx && rd_cmd_valid[m] &&
              rd_cmd_op[m] == OP_MAKE_INV && rd_cmd_addr[m] == g_addr)
            lost_nx[m] = 1'b1;
        end
      end
    end
  end

  // probe tracking
  logic [N_MASTERS-1:0] trk_mask;
  logic                 trk_empty_next;
  logic                 trk_kept;

  coh_probe_tracker #(.N_MASTERS(N_MASTERS), .ID_W(ID_W)) u_trk (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (ev_accept),
    .load_mask     (g_mask),
    .share_probe   (cur_op == OP_RD_SHARED),
    .cur_id        (cur_id),
    .prb_rsp_valid (prb_rsp_valid),
    .prb_rsp_kept  (prb_rsp_kept),
    .wr_valid      (wr_cmd_valid),
    .wr_kind       (wr_cmd_kind),
    .wr_tagged     (wr_cmd_tagged),
    .wr_id         (wr_cmd_id),
    .mask          (trk_mask),
    .empty_next    (trk_empty_next),
    .kept          (trk_kept)
  );

  // backing memory, written by every data-carrying write
  logic [N_MASTERS-1:0]             mem_we;
  logic [N_MASTERS-1:0][IDX_W-1:0]  mem_widx;
  logic [DATA_W-1:0]                mem_rdata;

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_wport
    assign mem_we[m]   = wr_cmd_valid[m] && wr_has_data(wr_cmd_kind[m]) &&
                         (wr_cmd_addr[m] < ADDR_W'(MAP_WORDS));
    assign mem_widx[m] = wr_cmd_addr[m][IDX_W-1:0];
  end

  coh_backing_mem #(.N_PORTS(N_MASTERS), .DEPTH(MAP_WORDS), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mem_we),
    .wr_idx  (mem_widx),
    .wr_data (wr_cmd_data),
    .rd_idx  (cur_addr[IDX_W-1:0]),
    .rd_data (mem_rdata)
  );

  // sequencing
  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (ev_accept) state_nx = ST_ISSUE;
      ST_ISSUE: state_nx = ST_WAIT;
      ST_WAIT:  if (trk_empty_next) state_nx = ST_RESP;
      ST_RESP:  if (rd_rsp_ready) state_nx = ST_ACK;
      ST_ACK:   if (ev_ack) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_src  <= '0;
      cur_op   <= '0;
      cur_addr <= '0;
      cur_id   <= '0;
      cur_kind <= '0;
      txn_ctr  <= '0;
      lost     <= '0;
    end else begin
      state <= state_nx;
      lost  <= lost_nx;
      if (ev_accept) begin
        cur_src  <= g_idx;
        cur_op   <= g_op;
        cur_addr <= g_addr;
        cur_id   <= txn_ctr;
        cur_kind <= g_kind;
        txn_ctr  <= txn_ctr + 1'b1;
      end
    end
  end

  // outputs
  logic [1:0] flags;
  assign flags = grant_flags(cur_op, cur_kind, trk_kept);

  assign prb_cmd_valid = ev_issue ? trk_mask : '0;
  assign prb_cmd_share = (cur_op == OP_RD_SHARED);
  assign prb_cmd_id    = cur_id;
  assign prb_cmd_addr  = cur_addr;

  assign rd_rsp_valid  = (state == ST_RESP);
  assign rd_rsp_dst    = cur_src;
  assign rd_rsp_kind   = cur_kind;
  assign rd_rsp_data   = (rd_rsp_valid && cur_kind == RSP_DATA) ? mem_rdata : '0;
  assign rd_rsp_shared = rd_rsp_valid && flags[1];
  assign rd_rsp_owner  = rd_rsp_valid && flags[0];

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_cmd_ready & rd_cmd_valid)); // R1

  AST_NO_SELF_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |-> !prb_cmd_valid[cur_src]); // R3

  AST_RSP_AFTER_PROBES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid |-> (trk_mask == '0)); // R4

  AST_ONCE_NO_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_issue && cur_op == OP_RD_ONCE) |-> (prb_cmd_valid == '0)); // R5

  AST_ERR_NO_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_issue && cur_kind == RSP_ERR) |-> (prb_cmd_valid == '0)); // R9

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && !rd_rsp_ready) |=> (rd_rsp_valid && $stable(rd_rsp_kind) && $stable(rd_rsp_dst))); // R11

  AST_NO_ACCEPT_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp_fire |=> (rd_cmd_ready == '0)); // R11
endmodule

// File: tb/coh_read_seq_tb.sv
module coh_read_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam int MAPW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NM-1:0]          rcv = '0;
  logic [NM-1:0]          rdy;
  logic [NM-1:0][1:0]     rop = '0;
  logic [NM-1:0][AW-1:0]  raddr = '0;
  logic                   rsp_v;
  logic                   rsp_rdy = 1'b1;
  logic [1:0]             rsp_dst;
  logic [1:0]             rsp_kind;
  logic [DW-1:0]          rsp_data;
  logic                   rsp_sh, rsp_own;
  logic [NM-1:0]          ack = '0;
  logic [NM-1:0]          prb_v;
  logic                   prb_sh;
  logic [IW-1:0]          prb_id;
  logic [AW-1:0]          prb_addr;
  logic [NM-1:0]          prs = '0;
  logic [NM-1:0]          pkept = '0;
  logic [NM-1:0]          wv = '0;
  logic [NM-1:0][1:0]     wkind = '0;
  logic [NM-1:0]          wtag = '0;
  logic [NM-1:0][IW-1:0]  wid = '0;
  logic [NM-1:0][AW-1:0]  waddr = '0;
  logic [NM-1:0][DW-1:0]  wdata = '0;

  coh_read_seq #(.N_MASTERS(NM), .ADDR_W(AW), .DATA_W(DW), .MAP_WORDS(MAPW), .ID_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_cmd_valid(rcv), .rd_cmd_ready(rdy), .rd_cmd_op(rop), .rd_cmd_addr(raddr),
    .rd_rsp_valid(rsp_v), .rd_rsp_ready(rsp_rdy), .rd_rsp_dst(rsp_dst), .rd_rsp_kind(rsp_kind),
    .rd_rsp_data(rsp_data), .rd_rsp_shared(rsp_sh), .rd_rsp_owner(rsp_own),
    .rd_ack_valid(ack),
    .prb_cmd_valid(prb_v), .prb_cmd_share(prb_sh), .prb_cmd_id(prb_id), .prb_cmd_addr(prb_addr),
    .prb_rsp_valid(prs), .prb_rsp_kept(pkept),
    .wr_cmd_valid(wv), .wr_cmd_kind(wkind), .wr_cmd_tagged(wtag), .wr_cmd_id(wid),
    .wr_cmd_addr(waddr), .wr_cmd_data(wdata)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_phase = 0;   // 0 idle, 1 probe out, 2 waiting, 3 answering, 4 awaiting ack
  int          m_src, m_op, m_addr, m_kind, m_ctr, m_id;
  bit          m_pend [NM];
  bit          m_lost [NM];
  bit          m_kept;
  int          m_mem  [MAPW];
  int          acc_m;

  function automatic int first_req();
    for (int m = 0; m < NM; m++) if (rcv[m]) return m;
    return -1;
  endfunction

  function automatic bit nothing_pending();
    for (int m = 0; m < NM; m++) if (m_pend[m]) return 0;
    return 1;
  endfunction

  task automatic model_edge();
    int g;
    bit probing;
    acc_m = -1;
    if (!rst_n) begin
      m_phase = 0; m_kept = 0; m_ctr = 0;
      for (int m = 0; m < NM; m++) begin m_pend[m] = 0; m_lost[m] = 0; end
      for (int i = 0; i < MAPW; i++) m_mem[i] = 0;
      return;
    end
    for (int m = 0; m < NM; m++) begin
      bit hitw;
      hitw = wv[m] && wtag[m] && (wkind[m] < 2) && (int'(wid[m]) == m_id);
      if (m_pend[m] && (prs[m] || hitw)) begin
        m_pend[m] = 0;
        if (m_op == 0 && ((prs[m] && pkept[m]) || (hitw && wkind[m] == 2'd1))) m_kept = 1;
      end
    end
    for (int m = 0; m < NM; m++)
      if (wv[m] && wkind[m] < 2 && int'(waddr[m]) < MAPW) m_mem[int'(waddr[m])] = int'(wdata[m]);
    case (m_phase)
      0: begin
        g = first_req();
        if (g >= 0) begin
          acc_m = g; m_src = g; m_op = int'(rop[g]); m_addr = int'(raddr[g]);
          m_id = m_ctr % 16; m_ctr++;
          if (m_addr >= MAPW) m_kind = 3;
          else if (m_lost[g] && m_op == 3) m_kind = 2;
          else if (m_op == 3) m_kind = 1;
          else m_kind = 0;
          probing = (m_kind <= 1) && (m_op != 2);
          for (int m = 0; m < NM; m++) m_pend[m] = probing && (m != g);
          m_kept = 0;
          m_lost[g] = 0;
          if (probing && (m_op == 1 || m_op == 3))
            for (int m = 0; m < NM; m++)
              if (m != g && rcv[m] && rop[m] == 2'd3 && int'(raddr[m]) == m_addr) m_lost[m] = 1;
          m_phase = 1;
        end
      end
      1: m_phase = 2;
      2: if (nothing_pending()) m_phase = 3;
      3: if (rsp_rdy) m_phase = 4;
      4: if (ack[m_src]) m_phase = 0;
      default: m_phase = 0;
    endcase
  endtask

  task automatic compare_all();
    logic [NM-1:0] e_rdy, e_prb;
    int g;
    bit e_sh, e_own;
    if (!rst_n) return;
    g = first_req();
    e_rdy = (m_phase == 0 && g >= 0) ? NM'(1 << g) : '0;
    chk("R1 ready", rdy, e_rdy);
    e_prb = '0;
    if (m_phase == 1) for (int m = 0; m < NM; m++) e_prb[m] = m_pend[m];
    chk("R3 probe targets", prb_v, e_prb);
    if (e_prb != '0) begin
      chk("R2 probe share", prb_sh, (m_op == 0));
      chk("R2 probe id", prb_id, m_id);
      chk("R2 probe addr", prb_addr, m_addr);
    end
    chk("R4 rsp valid", rsp_v, (m_phase == 3));
    if (m_phase == 3) begin
      chk("R11 rsp dst", rsp_dst, m_src);
      chk("R10 rsp kind", rsp_kind, m_kind);
      if (m_kind == 0) chk("R7 rsp data", rsp_data, m_mem[m_addr]);
      e_sh  = (m_kind == 0) && (m_op == 0) && m_kept;
      e_own = (m_kind == 1) || ((m_kind == 0) && (m_op == 1 || (m_op == 0 && !m_kept)));
      chk("R6 shared flag", rsp_sh, e_sh);
      chk("R6 owner flag", rsp_own, e_own);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    cycles++;
  endtask

  // ---------------- stimulus helpers ----------------
  task automatic clear_pulses();
    ack = '0; prs = '0; pkept = '0; wv = '0; wtag = '0;
  endtask

  task automatic send(input int m, input logic [1:0] op, input logic [AW-1:0] a);
    int n;
    rcv[m] = 1'b1; rop[m] = op; raddr[m] = a;
    n = 0;
    do begin step(); n++; end while (acc_m != m && n < 40);
    rcv[m] = 1'b0;
    chk("R1 accepted", (acc_m == m), 1'b1);
  endtask

  task automatic expect_rsp(input string tag, input logic [1:0] kind, input logic [DW-1:0] data,
                            input logic sh, input logic own);
    int n;
    n = 0;
    while (!rsp_v && n < 40) begin step(); n++; end
    chk({tag, " valid"}, rsp_v, 1'b1);
    chk({tag, " kind"}, rsp_kind, kind);
    if (kind == 2'd0) chk({tag, " data"}, rsp_data, data);
    chk({tag, " shared"}, rsp_sh, sh);
    chk({tag, " owner"}, rsp_own, own);
  endtask

  task automatic finish_txn(input int src);
    step();
    ack[src] = 1'b1;
    step();
    ack = '0;
  endtask

  task automatic write1(input int m, input logic [1:0] k, input logic tg, input logic [IW-1:0] id,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
    wv[m] = 1'b1; wkind[m] = k; wtag[m] = tg; wid[m] = id; waddr[m] = a; wdata[m] = d;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    #1;
    chk("R12 reset rsp", rsp_v, 1'b0);
    chk("R12 reset probe", prb_v, 3'b000);

    // preload memory with plain writes (R7)
    write1(0, 2'd0, 1'b0, 4'd0, 8'd3, 32'h0000_00A3);
    write1(1, 2'd0, 1'b0, 4'd0, 8'd5, 32'h0000_0055);
    step(); clear_pulses(); step();

    // readShared, one master keeps its copy (R2, R3, R6)
    send(0, 2'd0, 8'd3);
    chk("R3 shared probe set", prb_v, 3'b110);
    chk("R2 shared probe kind", prb_sh, 1'b1);
    chk("R2 first id", prb_id, 4'd0);
    step();
    prs[1] = 1'b1; pkept[1] = 1'b1; step(); clear_pulses();
    chk("R4 one probe still open", rsp_v, 1'b0);
    prs[2] = 1'b1; step(); clear_pulses();
    chk("R4 rsp next cycle", rsp_v, 1'b1);
    expect_rsp("R6 kept shared", 2'd0, 32'hA3, 1'b1, 1'b0);
    finish_txn(0);

    // readUnique, evict does not complete, tagged write-back does (R3, R4, R7)
    send(1, 2'd1, 8'd5);
    chk("R3 unique probe set", prb_v, 3'b101);
    chk("R3 unique probe kind", prb_sh, 1'b0);
    chk("R2 second id", prb_id, 4'd1);
    step();
    write1(2, 2'd2, 1'b1, 4'd1, 8'd5, 32'hDEAD); step(); clear_pulses(); step();
    chk("R4 evict no completion", rsp_v, 1'b0);
    write1(0, 2'd0, 1'b1, 4'd1, 8'd5, 32'h77); step(); clear_pulses(); step();
    chk("R4 waits for last master", rsp_v, 1'b0);
    prs[2] = 1'b1; step(); clear_pulses();
    expect_rsp("R7 forwarded write-back", 2'd0, 32'h77, 1'b0, 1'b1);
    finish_txn(1);

    // readOnce (R5)
    send(2, 2'd2, 8'd3);
    chk("R5 no probe", prb_v, 3'b000);
    expect_rsp("R5 untracked", 2'd0, 32'hA3, 1'b0, 1'b0);
    finish_txn(2);

    // unmapped address (R9)
    send(0, 2'd0, 8'd20);
    chk("R9 no probe", prb_v, 3'b000);
    expect_rsp("R9 error", 2'd3, 32'h0, 1'b0, 1'b0);
    finish_txn(0);

    // make-invalid race (R1, R10)
    rcv[1] = 1'b1; rop[1] = 2'd3; raddr[1] = 8'd7;
    rcv[2] = 1'b1; rop[2] = 2'd3; raddr[2] = 8'd7;
    #1;
    chk("R1 lowest wins", rdy, 3'b010);
    step(); rcv[1] = 1'b0;
    chk("R3 make-invalid probe set", prb_v, 3'b101);
    chk("R3 make-invalid probe kind", prb_sh, 1'b0);
    step();
    prs[0] = 1'b1; prs[2] = 1'b1; step(); clear_pulses();
    expect_rsp("R10 success", 2'd1, 32'h0, 1'b0, 1'b1);
    finish_txn(1);
    begin
      int n;
      n = 0;
      do begin step(); n++; end while (acc_m != 2 && n < 40);
      rcv[2] = 1'b0;
    end
    chk("R10 loser no probe", prb_v, 3'b000);
    expect_rsp("R10 abort", 2'd2, 32'h0, 1'b0, 1'b0);
    finish_txn(2);

    // two requests, write during wait, stalled response, wrong ack (R1, R6, R8, R11)
    rcv[0] = 1'b1; rop[0] = 2'd0; raddr[0] = 8'd5;
    rcv[2] = 1'b1; rop[2] = 2'd2; raddr[2] = 8'd9;
    #1;
    chk("R1 lowest of two", rdy, 3'b001);
    step(); rcv[0] = 1'b0;
    chk("R2 seventh id", prb_id, 4'd6);
    chk("R1 busy while open", rdy, 3'b000);
    step();
    rsp_rdy = 1'b0;
    write1(2, 2'd0, 1'b0, 4'd0, 8'd9, 32'h1234);
    write1(1, 2'd1, 1'b1, 4'd6, 8'd5, 32'h88);
    prs[2] = 1'b1;
    step(); clear_pulses();
    expect_rsp("R6 write-share keeps", 2'd0, 32'h88, 1'b1, 1'b0);
    repeat (3) step();
    chk("R11 held", rsp_v, 1'b1);
    chk("R11 held dst", rsp_dst, 2'd0);
    rsp_rdy = 1'b1;
    step();
    chk("R11 taken", rsp_v, 1'b0);
    chk("R11 no accept before ack", rdy, 3'b000);
    ack[2] = 1'b1; step(); ack = '0;
    chk("R11 foreign ack ignored", rdy, 3'b000);
    ack[0] = 1'b1; step(); ack = '0;
    begin
      int n;
      n = 0;
      while (acc_m != 2 && n < 40) begin step(); n++; end
      rcv[2] = 1'b0;
    end
    expect_rsp("R8 write during wait", 2'd0, 32'h1234, 1'b0, 1'b0);
    finish_txn(2);

    repeat (3) step();
    summary();
  end
endmodule